// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block takes return-to-zero ARINC 429 traffic as two digital rail signals, already squared up by an external line receiver, and rebuilds the 32-bit words it carries. Each bit is decoded from the rail pair and shifted into an input register. A quiet-time counter, run from the sampling clock, finds the gap between words. At each gap the block checks the number of bits received and, if enabled, odd parity. A good word is then handed to the receive buffer register with a one-cycle strobe. A bad bit count raises an error flag instead.

A test-mode input routes two digital test pins into the detection logic in place of the line-receiver rails, so the receiver can be driven by another source. After reset the receiver stays idle until it has seen one full word gap. This keeps it from accepting a word that was already partly on the wire when reset was released.

Top module: `a429_word_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released, `word_out` is 0, `word_stb` is 0 and `err` is 0 until a word or an error is reported.
- R2: The rail pair is read as {A,B}. 10 is a one, 01 is a zero, 00 is the null level and 11 carries no bit. A bit is taken each time the pair moves from 00 to 10 or 01. The first bit received lands in `word_out[0]` and the 32nd in `word_out[31]`.
- R3: A word gap is declared once the sampled rail pair has been unchanged for 17 consecutive sampling clocks. Any change of the pair restarts that count, so a quiet period shorter than 17 clocks does not split a word.
- R4: At a word gap where exactly 32 bits have arrived since the previous gap, `word_out` is loaded with the word, `word_stb` is high for exactly one cycle and `err` goes low.
- R5: At a word gap where the bit count is not 32 (fewer or more), `err` goes high, `word_stb` stays low and `word_out` keeps its previous value.
- R6: With `par_en` high, a stored word whose 32 bits have even parity gets `word_out[31]` forced to 1. A word with odd parity is stored unchanged.
- R7: With `par_en` low, `word_out[31]` is the 32nd bit as received, whatever the parity.
- R8: After reset, the bits and the bit count seen before the first word gap are discarded. That first gap produces neither a strobe nor an error.
- R9: With `test_mode` high, `test_a` and `test_b` take the place of `line_a` and `line_b` as the rail pair. With `test_mode` low, the line rails are used.
- R10: The outputs update at the 18th rising clock edge after the edge that first samples the final rail change before a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; also clocks the gap counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_a | input | 1 | A rail from the line receiver |
| line_b | input | 1 | B rail from the line receiver |
| test_mode | input | 1 | High selects the test rails |
| test_a | input | 1 | A rail in test mode |
| test_b | input | 1 | B rail in test mode |
| par_en | input | 1 | High enables the odd-parity check on bit 32 |
| word_out | output | 32 | Receive buffer; bit 0 is the first bit received |
| word_stb | output | 1 | One-cycle pulse when a word is transferred |
| err | output | 1 | Bit-count error flag |

## Verification
The receiver is driven with several kinds of traffic:
- A partial word straight after reset shows whether the hold-off works.
- One word sent with odd parity and another with even parity, under both settings of the parity enable, separates forcing bit 32 from passing it through.
- Words of 31 and 33 bits exercise the count error and show that the buffer is left untouched.
- A word split by a pause shorter than the gap tests the quiet-time threshold.
- A word with a both-rails-high pulse inside it, and a word sent through the test inputs while the line rails sit at a fixed level, check rail decoding and source selection.

A behavioural model built on a bit queue and a quiet counter follows every clock, which pins down the exact output edge.

// File: rtl/a429rx_pkg.sv
package a429rx_pkg;

    // Rail pair encoding, written {A,B}
    typedef enum logic [1:0] {
        RAIL_NULL = 2'b00,
        RAIL_ZERO = 2'b01,
        RAIL_ONE  = 2'b10,
        RAIL_BAD  = 2'b11
    } rail_e;

    // True when a code is one of the two data levels
    function automatic logic rail_is_data(input logic [1:0] code);
        return (code == RAIL_ONE) || (code == RAIL_ZERO);
    endfunction

endpackage

// File: rtl/a429rx_sampler.sv
module a429rx_sampler
    import a429rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic line_a,
    input  logic line_b,
    input  logic test_a,
    input  logic test_b,
    output logic activity,
    output logic bit_vld,
    output logic bit_val
);

    typedef struct packed {
        logic [1:0] cur;
        logic [1:0] prv;
    } smp_t;

    smp_t s_d, s_q;
    logic [1:0] src_pair;

    always_comb begin
        src_pair = test_mode ? {test_a, test_b} : {line_a, line_b};
        s_d      = s_q;
        s_d.cur  = src_pair;
        s_d.prv  = s_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // A change of the sampled pair is bus activity; a bit is the
    // rising move from null into one of the data levels.
    assign activity = (s_q.cur != s_q.prv);
    assign bit_vld  = (s_q.prv == RAIL_NULL) && rail_is_data(s_q.cur);
    assign bit_val  = (s_q.cur == RAIL_ONE);

endmodule

// File: rtl/a429rx_gap_timer.sv
module a429rx_gap_timer #(
    parameter int GAP_CLKS = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    output logic gap
);

    localparam int GW = $clog2(GAP_CLKS + 1);
    localparam logic [GW-1:0] CNT_TOP  = GW'(GAP_CLKS);
    localparam logic [GW-1:0] CNT_LAST = GW'(GAP_CLKS - 1);

    typedef struct packed {
        logic [GW-1:0] quiet;
    } gt_t;

    gt_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (activity) begin
            g_d.quiet = '0;
        end else if (g_q.quiet != CNT_TOP) begin
            g_d.quiet = g_q.quiet + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    // Fires once per quiet stretch; the count then rests at its top
    assign gap = !activity && (g_q.quiet == CNT_LAST);

endmodule

// File: rtl/a429rx_assembler.sv
module a429rx_assembler #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              gap,
    input  logic              par_en,
    output logic [WORD_W-1:0] word,
    output logic              stb,
    output logic              err,
    output logic              armed
);

    localparam int CW = $clog2(WORD_W + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);
    localparam logic [CW-1:0] CNT_SAT  = CW'(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CW-1:0]     nbits;
        logic              armed;
        logic [WORD_W-1:0] word;
        logic              stb;
        logic              err;
    } asm_t;

    asm_t a_d, a_q;
    logic              par_bad;
    logic [WORD_W-1:0] checked;

    always_comb begin
        par_bad = !(^a_q.shreg);
        checked = {(par_en && par_bad) ? 1'b1 : a_q.shreg[WORD_W-1],
                   a_q.shreg[WORD_W-2:0]};

        a_d     = a_q;
        a_d.stb = 1'b0;

        if (bit_vld) begin
            a_d.shreg = {bit_val, a_q.shreg[WORD_W-1:1]};
            if (a_q.nbits != CNT_SAT) begin
                a_d.nbits = a_q.nbits + 1'b1;
            end
        end

        if (gap) begin
            a_d.nbits = '0;
            a_d.armed = 1'b1;
            if (a_q.armed) begin
                if (a_q.nbits == CNT_FULL) begin
                    a_d.word = checked;
                    a_d.stb  = 1'b1;
                    a_d.err  = 1'b0;
                end else begin
                    a_d.err  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign word  = a_q.word;
    assign stb   = a_q.stb;
    assign err   = a_q.err;
    assign armed = a_q.armed;

endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx #(
    parameter int WORD_W   = 32,
    parameter int GAP_CLKS = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_a,
    input  logic              line_b,
    input  logic              test_mode,
    input  logic              test_a,
    input  logic              test_b,
    input  logic              par_en,
    output logic [WORD_W-1:0] word_out,
    output logic              word_stb,
    output logic              err
);

    logic act_w;
    logic bit_vld_w;
    logic bit_val_w;
    logic gap_w;
    logic armed_w;

    a429rx_sampler u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .line_a    (line_a),
        .line_b    (line_b),
        .test_a    (test_a),
        .test_b    (test_b),
        .activity  (act_w),
        .bit_vld   (bit_vld_w),
        .bit_val   (bit_val_w)
    );

    a429rx_gap_timer #(.GAP_CLKS(GAP_CLKS)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .activity (act_w),
        .gap      (gap_w)
    );

    a429rx_assembler #(.WORD_W(WORD_W)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld_w),
        .bit_val (bit_val_w),
        .gap     (gap_w),
        .par_en  (par_en),
        .word    (word_out),
        .stb     (word_stb),
        .err     (err),
        .armed   (armed_w)
    );

endmodule

// File: rtl/a429_word_rx_chk.sv
module a429_word_rx_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_stb,
    input logic              err,
    input logic              armed,
    input logic              activity,
    input logic              par_en,
    input logic [WORD_W-1:0] word_out
);

    p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);

    p_stb_clears_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> !err);

    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_out != $past(word_out)) |-> word_stb);

    p_err_no_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !word_stb);

    p_parity_fix_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && par_en && !word_out[WORD_W-1]) |-> (^word_out));

    p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!word_stb && !err));

    p_gap_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb || $rose(err)) |-> $past(!activity));

endmodule

bind a429_word_rx a429_word_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_stb (word_stb),
    .err      (err),
    .armed    (armed_w),
    .activity (act_w),
    .par_en   (par_en),
    .word_out (word_out)
);

// File: tb/a429_word_rx_bench.sv
module a429_word_rx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_a = 1'b0, line_b = 1'b0;
    logic        test_mode = 1'b0, test_a = 1'b0, test_b = 1'b0;
    logic        par_en = 1'b1;
    logic [31:0] word_out;
    logic        word_stb;
    logic        err;

    int n_chk  = 0;
    int n_fail = 0;
    int stb_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    a429_word_rx u_a429_word_rx (
        .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
        .test_mode(test_mode), .test_a(test_a), .test_b(test_b),
        .par_en(par_en), .word_out(word_out), .word_stb(word_stb), .err(err)
    );

    // Behavioural reference: a queue of bits and a quiet-clock counter
    logic [1:0]  m_now, m_old;
    int          m_quiet;
    bit          m_armed;
    bit          m_q[$];
    logic [31:0] m_word;
    logic        m_stb, m_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_now = 2'b00; m_old = 2'b00; m_quiet = 0; m_armed = 0;
            m_q.delete(); m_word = 32'h0; m_stb = 0; m_err = 0;
        end else begin
            logic [1:0]  pin;
            bit          moved, gap_now;
            logic [31:0] w;
            pin     = test_mode ? {test_a, test_b} : {line_a, line_b};
            moved   = (m_now != m_old);
            gap_now = !moved && (m_quiet == 16);
            m_stb   = 0;
            if (moved) m_quiet = 0;
            else if (m_quiet < 17) m_quiet++;
            if (m_old == 2'b00 && (m_now == 2'b10 || m_now == 2'b01))
                m_q.push_back(m_now == 2'b10);
            if (gap_now) begin
                if (m_armed) begin
                    if (m_q.size() == 32) begin
                        for (int i = 0; i < 32; i++) w[i] = m_q[i];
                        if (par_en && !(^w)) w[31] = 1'b1;
                        m_word = w; m_stb = 1; m_err = 0;
                    end else begin
                        m_err = 1;
                    end
                end
                m_armed = 1;
                m_q.delete();
            end
            m_old = m_now;
            m_now = pin;
        end
    end

    // Cycle compare against the model (R10 timing, R2..R9 contents)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (word_out !== m_word || word_stb !== m_stb || err !== m_err) begin
                n_fail++;
                $display("FAIL R10 cycle compare: act word=%h stb=%b err=%b exp word=%h stb=%b err=%b",
                         word_out, word_stb, err, m_word, m_stb, m_err);
            end
        end
        if (word_stb === 1'b1) stb_seen++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] p);
        if (test_mode) {test_a, test_b} = p;
        else {line_a, line_b} = p;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); drive(b ? 2'b10 : 2'b01);
        @(negedge clk);
        @(negedge clk); drive(2'b00);
        @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] w, input int lo, input int n);
        for (int i = lo; i < lo + n; i++) send_bit(i < 32 ? w[i] : 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        check("R1 word_out in reset", word_out, 32'h0);
        check("R1 err in reset", {31'h0, err}, 32'h0);
        check("R1 stb in reset", {31'h0, word_stb}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        int s0;
        idle(2);
        do_reset();

        // R8: partial word right after reset is dropped
        send_bits(32'h0000_03FF, 0, 10);
        idle(25);
        check("R8 no strobe before arming", stb_seen, 0);
        check("R8 no error before arming", {31'h0, err}, 32'h0);

        // R4 / R6: odd-parity word stored as is
        par_en = 1'b1;
        send_bits(32'h8000_00A5, 0, 32); idle(25);
        check("R4 good word", word_out, 32'h8000_00A5);
        check("R4 one strobe", stb_seen, 1);
        check("R4 err low", {31'h0, err}, 32'h0);

        // R6: even parity, bit 32 forced
        send_bits(32'h0000_0003, 0, 32); idle(25);
        check("R6 parity fail marks bit 32", word_out, 32'h8000_0003);

        // R7: check off, bit 32 as received
        par_en = 1'b0;
        send_bits(32'h0000_0003, 0, 32); idle(25);
        check("R7 bit 32 as received", word_out, 32'h0000_0003);
        par_en = 1'b1;

        // R5: short and long words
        s0 = stb_seen;
        send_bits(32'h8000_00A5, 0, 31); idle(25);
        check("R5 short word err", {31'h0, err}, 32'h1);
        check("R5 short word keeps buffer", word_out, 32'h0000_0003);
        send_bits(32'h8000_00A5, 0, 33); idle(25);
        check("R5 long word err", {31'h0, err}, 32'h1);
        check("R5 no strobe on bad count", stb_seen, s0);

        // R2: a both-high pulse carries no bit; valid word clears err
        send_bits(32'h8000_00A5, 0, 16);
        @(negedge clk); drive(2'b11); idle(2); drive(2'b00); idle(2);
        send_bits(32'h8000_00A5, 16, 16); idle(25);
        check("R2 both-high ignored", word_out, 32'h8000_00A5);
        check("R4 valid word clears err", {31'h0, err}, 32'h0);

        // R3: pause below the gap length does not split the word
        send_bits(32'h0000_0F01, 0, 16); idle(12);
        send_bits(32'h0000_0F01, 16, 16); idle(25);
        check("R3 short pause keeps word whole", word_out, 32'h0000_0F01);
        check("R3 no error", {31'h0, err}, 32'h0);

        // R9: test inputs drive the receiver, line rails parked high
        {line_a, line_b} = 2'b10;
        test_mode = 1'b1; {test_a, test_b} = 2'b00; idle(25);
        send_bits(32'h1234_5678, 0, 32); idle(25);
        check("R9 test-mode word", word_out, 32'h1234_5678);
        test_mode = 1'b0; {line_a, line_b} = 2'b00; idle(25);

        // R1: reset clears a pending error
        send_bits(32'h1, 0, 5); idle(25);
        check("R5 err before reset", {31'h0, err}, 32'h1);
        do_reset();
        idle(2);
        check("R1 err cleared by reset", {31'h0, err}, 32'h0);
        check("R1 word cleared by reset", word_out, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule